// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

This block writes a run of 16-bit words into a one-time-programmable memory array whose cells read as one when blank and can only be driven from one to zero. Software or an upstream engine gives it a start strobe, a base address and a word count. The block then asks a data source for one word per address through a ready/valid handshake. Each address receives fixed-length program pulses. After every pulse the word is read back, and pulsing stops as soon as the read word equals the intended word. A per-address limit on pulses ends the run with a failure. After the last address, the whole range is read again against a second delivery of the same words from the source.

The controller drives the memory's active-low chip-enable/program strobe, its active-low output-enable, the address, and a 16-bit write bus with a separate drive enable. It samples a 16-bit read bus. Supply switching is outside the block. Two status flags tell the supply logic whether the high-voltage programming phase or the final-verify phase is running. Completion, the pass/fail result and the first failing address are held until the next start.

State machine: `ST_IDLE` (after reset) and `ST_DONE` (after a run) wait for `start`. A start with a zero count goes straight to `ST_DONE`. Any other start goes to `ST_FETCH`, which waits for a source word. It then moves to `ST_PULSE`, which holds for the pulse length. `ST_READ` is the read-back after the pulse. `ST_CHECK` compares the read word with the intended word. On a mismatch it returns to `ST_PULSE`. When the cap is reached it goes to `ST_DONE` with a failure. On a match it goes to the next address in `ST_FETCH`, or, after the last address, to the final pass. The final pass runs `ST_FV_FETCH` → `ST_FV_READ` → `ST_FV_CHECK` for each address. A mismatch there goes to `ST_DONE` with a failure. A match on the last address goes to `ST_DONE` with a pass.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: A `start` seen in idle or done latches `base_addr` and `word_count` and begins at the base address. A zero `word_count` raises `done` with `pass`=1 in the next cycle and issues no pulse.
- R2: A program pulse drives `mem_ce_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1 and `hv_mode`=1, with the intended word on `mem_dq_o`. It lasts exactly CLK_HZ·PULSE_US/10^6 clock cycles.
- R3: After every pulse, `mem_oe_n`=0 and `mem_ce_n`=1 are held for READ_CYC cycles with `hv_mode`=1. The read bus is sampled in the last of those cycles and compared with the intended word.
- R4: A mismatched read-back is followed by another pulse, and a match ends pulsing for that address. An address whose cells need k pulses receives exactly k pulses when k ≤ MAX_PULSES.
- R5: Addresses are handled in ascending order, each finished before the next begins. `src_ready` is high while a word is awaited and the word is taken on the clock edge where `src_valid` is also high. The source is asked for exactly one word per address in each pass.
- R6: If the read-back still differs after MAX_PULSES pulses, the run ends with `done`=1, `pass`=0 and `fail_addr` set to that address. No later address is pulsed.
- R7: After the last address programs, `vfy_mode`=1 and `hv_mode`=0. Each address from the base is read again with `mem_ce_n`=0 and `mem_oe_n`=0 and compared with a fresh source word. The first mismatch gives `pass`=0 and its address in `fail_addr`. No mismatch gives `pass`=1, and this pass issues no pulses.
- R8: Reset gives `done`=0, `pass`=0, `fail_addr`=0, `mem_ce_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `src_ready`=0 and both mode flags low. After a run, `done`, `pass` and `fail_addr` hold until the next `start`, and `fail_addr` reads 0 after a pass.
- R9: The write bus is never driven (`mem_dq_oe`=0) while `mem_oe_n`=0.
- R10: A target word with a one in a bit that already holds zero never reads back equal. That address therefore ends in the pulse-cap failure of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| base_addr | input | AW | First word address |
| word_count | input | AW+1 | Number of words |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word for the current address |
| src_ready | output | 1 | Controller awaits a source word |
| mem_ce_n | output | 1 | Chip-enable / program strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Memory word address |
| mem_dq_o | output | DW | Write data bus |
| mem_dq_oe | output | 1 | Write bus drive enable |
| mem_dq_i | input | DW | Read data bus |
| hv_mode | output | 1 | Programming phase (high programming supply) |
| vfy_mode | output | 1 | Final-verify phase (nominal supply) |
| done | output | 1 | Run finished |
| pass | output | 1 | Run succeeded (valid with done) |
| fail_addr | output | AW | First failing address |

## Verification
The main function is tried with cells that need one pulse each and with a mix of one to four pulses. The mix separates a controller that stops on the first match from one that pulses a fixed number of times, and it lands exactly on the cap without failing. A range with a cell needing more than the cap separates abort-on-cap from carrying on. It also shows that later addresses stay blank. Reprogramming a word with a zero-to-one bit, and disturbing a cell between the phases, separate the in-loop failure from the final-verify failure. A zero count and a source that delays `src_valid` on odd addresses test the edges of the handshake.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PULSE,
        ST_READ,
        ST_CHECK,
        ST_FV_FETCH,
        ST_FV_READ,
        ST_FV_CHECK,
        ST_DONE
    } prog_state_e;

    localparam longint unsigned HZ_PER_MHZ = 64'd1000000;

endpackage

// File: rtl/eprom_cycle_timer.sv
module eprom_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_addr_walker.sv
module eprom_addr_walker #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   count,
    input  logic          rewind,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] addr_q;
    logic [AW:0]   count_q;
    logic [AW:0]   left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            count_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            base_q  <= base;
            addr_q  <= base;
            count_q <= count;
            left_q  <= count;
        end else if (rewind) begin
            addr_q <= base_q;
            left_q <= count_q;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (left_q == {{AW{1'b0}}, 1'b1});
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
    import eprom_prog_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int CLK_HZ     = 125_000_000,
    parameter int PULSE_US   = 100,
    parameter int READ_CYC   = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   word_count,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i,
    output logic          hv_mode,
    output logic          vfy_mode,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr
);
    localparam longint unsigned PULSE_CYC_L =
        (longint'(CLK_HZ) * longint'(PULSE_US)) / HZ_PER_MHZ;
    localparam int PULSE_CYC = int'(PULSE_CYC_L);
    localparam int LONGEST   = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
    localparam int TW        = $clog2(LONGEST) + 1;
    localparam int PCW       = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0]  PULSE_LOAD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0]  READ_LOAD  = TW'(READ_CYC - 1);
    localparam logic [PCW-1:0] PCAP       = PCW'(MAX_PULSES);

    prog_state_e state_q, state_d;

    logic [DW-1:0]  want_q, got_q;
    logic [PCW-1:0] pcnt_q;
    logic           pass_q;
    logic [AW-1:0]  fail_q;

    logic          tmr_load, tmr_pulse, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          w_load, w_rewind, w_step, w_last;
    logic          take_word, take_read, bump_pcnt;
    logic          end_pass, end_fail;
    logic          match;

    assign match   = (got_q == want_q);
    assign tmr_val = tmr_pulse ? PULSE_LOAD : READ_LOAD;

    eprom_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    eprom_addr_walker #(.AW(AW)) u_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (w_load),
        .base   (base_addr),
        .count  (word_count),
        .rewind (w_rewind),
        .step   (w_step),
        .addr   (mem_addr),
        .last   (w_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and datapath strobes
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_pulse = 1'b0;
        w_load    = 1'b0;
        w_rewind  = 1'b0;
        w_step    = 1'b0;
        take_word = 1'b0;
        take_read = 1'b0;
        bump_pcnt = 1'b0;
        end_pass  = 1'b0;
        end_fail  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    w_load = 1'b1;
                    if (word_count == '0) begin
                        state_d  = ST_DONE;
                        end_pass = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    take_word = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_pulse = 1'b1;
                    state_d   = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    bump_pcnt = 1'b1;
                    tmr_load  = 1'b1;
                    state_d   = ST_READ;
                end
            end
            ST_READ: begin
                if (tmr_exp) begin
                    take_read = 1'b1;
                    state_d   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (match) begin
                    if (w_last) begin
                        w_rewind = 1'b1;
                        state_d  = ST_FV_FETCH;
                    end else begin
                        w_step  = 1'b1;
                        state_d = ST_FETCH;
                    end
                end else if (pcnt_q >= PCAP) begin
                    end_fail = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    tmr_load  = 1'b1;
                    tmr_pulse = 1'b1;
                    state_d   = ST_PULSE;
                end
            end
            ST_FV_FETCH: begin
                if (src_valid) begin
                    take_word = 1'b1;
                    tmr_load  = 1'b1;
                    state_d   = ST_FV_READ;
                end
            end
            ST_FV_READ: begin
                if (tmr_exp) begin
                    take_read = 1'b1;
                    state_d   = ST_FV_CHECK;
                end
            end
            ST_FV_CHECK: begin
                if (!match) begin
                    end_fail = 1'b1;
                    state_d  = ST_DONE;
                end else if (w_last) begin
                    end_pass = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    w_step  = 1'b1;
                    state_d = ST_FV_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= '0;
            got_q  <= '0;
            pcnt_q <= '0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            if (take_word) begin
                want_q <= src_data;
                pcnt_q <= '0;
            end else if (bump_pcnt) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
            if (take_read) got_q <= mem_dq_i;
            if (w_load) begin
                pass_q <= 1'b0;
                fail_q <= '0;
            end
            if (end_pass) pass_q <= 1'b1;
            if (end_fail) fail_q <= mem_addr;
        end
    end

    // port outputs
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        src_ready = 1'b0;
        hv_mode   = 1'b0;
        vfy_mode  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                hv_mode   = 1'b1;
                src_ready = 1'b1;
            end
            ST_PULSE: begin
                hv_mode   = 1'b1;
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_READ: begin
                hv_mode  = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_CHECK: hv_mode = 1'b1;
            ST_FV_FETCH: begin
                vfy_mode  = 1'b1;
                src_ready = 1'b1;
            end
            ST_FV_READ: begin
                vfy_mode = 1'b1;
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_FV_CHECK: vfy_mode = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign mem_dq_o  = want_q;
    assign pass      = pass_q;
    assign fail_addr = fail_q;
endmodule

// File: rtl/eprom_prog_ctrl_chk.sv
module eprom_prog_ctrl_chk #(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int MAX_PULSES = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          src_valid,
    input logic          src_ready,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe,
    input logic          hv_mode,
    input logic          vfy_mode,
    input logic          done,
    input logic          pass,
    input logic [AW-1:0] fail_addr
);
    logic pulse_act, pulse_prev;
    int   pulse_cnt;

    assign pulse_act = !mem_ce_n && mem_oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_prev <= 1'b0;
            pulse_cnt  <= 0;
        end else begin
            pulse_prev <= pulse_act;
            if ((src_ready && src_valid && hv_mode) || start)
                pulse_cnt <= 0;
            else if (pulse_prev && !pulse_act)
                pulse_cnt <= pulse_cnt + 1;
        end
    end

    a_r9_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r2_pulse_in_hv: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_act |-> (hv_mode && mem_dq_oe));

    a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_mode && vfy_mode));

    a_r7_no_pulse_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_mode |-> (!mem_dq_oe && !pulse_act));

    a_r2_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_act && pulse_prev) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    a_r4_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= MAX_PULSES);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));

    a_r6_idle_bus_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && mem_oe_n && !src_ready));
endmodule

bind eprom_prog_ctrl eprom_prog_ctrl_chk #(
    .AW(AW), .DW(DW), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_valid(src_valid),
    .src_ready(src_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .hv_mode(hv_mode), .vfy_mode(vfy_mode), .done(done), .pass(pass),
    .fail_addr(fail_addr)
);

// File: tb/eprom_prog_ctrl_bench.sv
module eprom_prog_ctrl_bench;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int MAXP = 4;
    localparam int PCYC = 20;   // 200 kHz nominal * 100 us

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, src_valid = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   word_count = '0;
    logic [DW-1:0] src_data = '0;
    logic src_ready, mem_ce_n, mem_oe_n, mem_dq_oe, hv_mode, vfy_mode, done, pass;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    logic [DW-1:0] mem  [256];
    logic [DW-1:0] tgt  [256];
    int            need [256];
    int            pc   [256];
    int n_chk = 0, n_bad = 0, cyc = 0;
    int exp_addr = 0, plen = 0, wcnt = 0, dist_a = -1;
    logic pulse_prev = 1'b0, vfy_prev = 1'b0;
    logic [AW-1:0] a_prev = '0;
    logic [DW-1:0] d_prev = '0;

    assign mem_dq_i = mem_oe_n ? '1 : mem[mem_addr];

    eprom_prog_ctrl #(
        .AW(AW), .DW(DW), .CLK_HZ(200_000), .PULSE_US(100),
        .READ_CYC(2), .MAX_PULSES(MAXP)
    ) u_eprom_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .hv_mode(hv_mode), .vfy_mode(vfy_mode),
        .done(done), .pass(pass), .fail_addr(fail_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory cell model, source model and per-clock protocol reference
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pulse_prev && !( !mem_ce_n && mem_oe_n)) begin
                pc[a_prev]++;
                if (pc[a_prev] >= need[a_prev]) mem[a_prev] = mem[a_prev] & d_prev;
                chk(plen == PCYC, "R2", "pulse length", plen, PCYC);
                plen = 0;
            end
            if (!mem_ce_n && mem_oe_n) begin
                plen++;
                chk(hv_mode && mem_dq_oe && mem_dq_o == tgt[mem_addr], "R2",
                    "pulse drive", {hv_mode, mem_dq_oe, mem_dq_o}, {2'b11, tgt[mem_addr]});
                a_prev = mem_addr;
                d_prev = mem_dq_o;
            end
            pulse_prev = !mem_ce_n && mem_oe_n;
            if (!mem_oe_n) chk(!mem_dq_oe, "R9", "bus driven during read", mem_dq_oe, 0);
            if (!mem_oe_n && mem_ce_n)
                chk(hv_mode && !vfy_mode, "R3", "readback modes", {hv_mode, vfy_mode}, 2'b10);
            if (!mem_oe_n && !mem_ce_n)
                chk(vfy_mode && !hv_mode, "R7", "final read modes", {hv_mode, vfy_mode}, 2'b01);
            if (vfy_mode && !vfy_prev) begin
                exp_addr = int'(base_addr);
                if (dist_a >= 0) mem[dist_a] = mem[dist_a] | 16'h0100;
            end
            vfy_prev = vfy_mode;
            if (start) exp_addr = int'(base_addr);
            if (src_ready) begin
                if (wcnt == (mem_addr[0] ? 2 : 0)) begin
                    src_valid = 1'b1;
                    src_data  = tgt[mem_addr];
                    chk(int'(mem_addr) == exp_addr, "R5", "source order", mem_addr, exp_addr);
                    exp_addr++;
                end
                wcnt++;
            end else begin
                src_valid = 1'b0;
                wcnt = 0;
            end
        end
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input int b, input int n);
        for (int i = 0; i < 256; i++) pc[i] = 0;
        @(negedge clk);
        base_addr = AW'(b);
        word_count = (AW+1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    endtask

    task automatic result(input string req, input bit ep, input int fa);
        chk(done == 1'b1, req, "done", done, 1);
        chk(pass == ep, req, "pass", pass, ep);
        chk(int'(fail_addr) == fa, req, "fail_addr", fail_addr, fa);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '1; tgt[i] = '1; need[i] = 1; pc[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R8 reset state
        chk({done, pass, mem_ce_n, mem_oe_n, mem_dq_oe, src_ready, hv_mode, vfy_mode}
            == 8'b0011_0000, "R8", "reset outputs",
            {done, pass, mem_ce_n, mem_oe_n, mem_dq_oe, src_ready, hv_mode, vfy_mode}, 8'b0011_0000);
        chk(fail_addr == '0, "R8", "reset fail_addr", fail_addr, 0);
        rst_n = 1'b1;

        // R1 R4: one pulse per word
        tgt[16] = 16'h1234; tgt[17] = 16'hFFFF; tgt[18] = 16'h0000; tgt[19] = 16'hA5C3;
        run(16, 4);
        result("R1", 1'b1, 0);
        for (int a = 16; a < 20; a++) begin
            chk(pc[a] == 1, "R4", "pulses single", pc[a], 1);
            chk(mem[a] == tgt[a], "R7", "stored word", mem[a], tgt[a]);
        end
        repeat (5) @(negedge clk);
        chk(done && pass && fail_addr == '0, "R8", "result held", {done, pass}, 2'b11);

        // R4: mixed pulse needs, one exactly at the cap
        tgt[32] = 16'h0F0F; tgt[33] = 16'h7001; tgt[34] = 16'h8000;
        tgt[35] = 16'h00FF; tgt[36] = 16'h5555;
        need[32] = 1; need[33] = 3; need[34] = 2; need[35] = 4; need[36] = 1;
        run(32, 5);
        result("R4", 1'b1, 0);
        for (int a = 32; a < 37; a++)
            chk(pc[a] == need[a], "R4", "pulses mixed", pc[a], need[a]);

        // R6: cap reached on the middle word
        tgt[48] = 16'h1111; tgt[49] = 16'h2222; tgt[50] = 16'h3333;
        need[48] = 2; need[49] = 5; need[50] = 1;
        run(48, 3);
        result("R6", 1'b0, 49);
        chk(pc[48] == 2, "R6", "pulses before fail", pc[48], 2);
        chk(pc[49] == MAXP, "R6", "pulses at cap", pc[49], MAXP);
        chk(pc[50] == 0, "R6", "later address untouched", pc[50], 0);
        chk(mem[50] == 16'hFFFF, "R6", "later word blank", mem[50], 16'hFFFF);

        // R1: zero count
        run(64, 0);
        result("R1", 1'b1, 0);
        chk(pc[64] == 0, "R1", "no pulse on zero count", pc[64], 0);

        // R10: zero-to-one bit cannot be written
        tgt[16] = 16'h1235;
        run(16, 1);
        result("R10", 1'b0, 16);
        chk(pc[16] == MAXP, "R10", "pulses on impossible word", pc[16], MAXP);
        chk(mem[16] == 16'h1234, "R10", "cell keeps zeros", mem[16], 16'h1234);

        // R7: cell disturbed before final verify
        tgt[80] = 16'h0001; tgt[81] = 16'h0002; tgt[82] = 16'h0004;
        dist_a = 81;
        run(80, 3);
        dist_a = -1;
        result("R7", 1'b0, 81);
        for (int a = 80; a < 83; a++)
            chk(pc[a] == 1, "R7", "no pulses in final pass", pc[a], 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule